// File: doc/BRIEF.md
# Compare Match Timer Channel

One timer channel for a memory-mapped register bus. An up-counter advances on a count tick that is derived from a slow reference pulse through a selectable divider, and is compared against a programmable compare value. When they meet, a sticky match flag is raised. In periodic mode the counter also returns to zero, which gives a period of compare+1 ticks. When the counter runs past all ones and wraps to zero without a match, a sticky overflow flag is raised instead.

Software controls the channel through three 32-bit words: control/status, count and compare. The counter advances only while the channel's bit in an external start/stop vector is set. A match can drive an interrupt line, drive a DMA request pulse, or drive neither. A write to the count register lands in the slow count domain and takes effect only on the second count tick that follows it. A driver that clears the count therefore polls until zero reads back.

Top module: `cmt_channel`

## Requirements
- R1: After reset, control/status reads 0, count reads 0, compare reads all ones (zero-extended to 32 bits), the counter is held, and irq and dma_req are low.
- R2: Byte offset 0x0 selects control/status, 0x4 selects count and 0x8 selects compare. Control/status reads back bit 15 as the match flag, bit 14 as the overflow flag, bit 8 as periodic mode, bit 7 as the interrupt enable, bits 5:4 as routing and bits 2:0 as the tick select. Every other bit reads 0.
- R3: The counter changes only on a count tick while start_bits[CHAN_IDX] is 1. The other start bits have no effect.
- R4: Tick select 7 gives one count tick per reference pulse. Select 4 gives one per 8 pulses, 5 one per 32 and 6 one per 128. Selects 0 to 3 give no tick.
- R5: With periodic mode set and compare value N, the count runs 0..N and returns to 0 on the tick where it equals N, so one period lasts N+1 ticks.
- R6: With periodic mode clear, the counter keeps counting through a match and wraps from all ones to zero.
- R7: The match flag (bit 15) is set on the count tick where the count equals the compare value.
- R8: Writing control/status with bit 15 or bit 14 at 0 clears that flag. Writing it at 1 leaves the flag unchanged.
- R9: The overflow flag (bit 14) is set when the counter wraps from all ones to zero. A wrap caused by a match at all ones does not set it.
- R10: irq is high exactly while the match flag is set, the interrupt enable (bit 7) is 1 and routing is 2.
- R11: With routing 1, dma_req pulses for one clock cycle after each match. With any other routing it stays low.
- R12: A count write is not visible on reads and does not alter counting until the second count tick after it. On that tick the written value is loaded in place of the increment.
- R13: A compare write takes effect at once. If the counter is already above the new value, no match occurs until the counter wraps and reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse from the slow reference clock |
| start_bits | input | START_W | External start/stop vector, bit CHAN_IDX runs this channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when rd_en is low |
| irq | output | 1 | Compare-match interrupt request |
| dma_req | output | 1 | Compare-match DMA request pulse |

## Verification
The embedded properties watch, on every cycle, that the count holds between ticks, that a periodic match is followed by a zero count, that flags and DMA pulses rise only after a match or wrap event, that a pending count write never loads on the cycle after it, and that divided ticks never come back to back. The period length, the divider ratios, write-to-clear against write-one-to-keep, the two-tick delay of count writes and the missed match after lowering the compare value all need whole sequences. Only the bench's sweeps show them, with expected counts and flags worked out arithmetically from the number of reference pulses applied.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int REG_W = 32;
  localparam int ADDR_W = 4;
  localparam int PRE_W = 7;

  localparam logic [ADDR_W-1:0] OFF_CSR = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_CNT = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_CMP = 4'h8;

  localparam int BIT_MATCH    = 15;
  localparam int BIT_OVF      = 14;
  localparam int BIT_PERIODIC = 8;
  localparam int BIT_IRQ_EN   = 7;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_DMA  = 2'd1,
    ROUTE_IRQ  = 2'd2,
    ROUTE_RSVD = 2'd3
  } route_e;

  typedef struct packed {
    logic       periodic;
    logic       irq_en;
    route_e     route;
    logic [2:0] tick_sel;
  } ctl_t;

  // Reference pulses per count tick, minus one. Selects below 4 give no tick.
  function automatic logic [PRE_W-1:0] tick_limit(input logic [2:0] sel);
    case (sel)
      3'd4:    return PRE_W'(7);
      3'd5:    return PRE_W'(31);
      3'd6:    return PRE_W'(127);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic [2:0] tick_sel,
  output logic       cnt_tick
);
  logic [PRE_W-1:0] div_q, div_d;
  logic [PRE_W-1:0] lim;
  logic             sel_ok;
  logic             at_lim;

  assign sel_ok   = tick_sel[2];
  assign lim      = tick_limit(tick_sel);
  assign at_lim   = (div_q >= lim);
  assign cnt_tick = sel_ok && ref_tick && at_lim;

  always_comb begin
    div_d = div_q;
    if (!sel_ok)      div_d = '0;
    else if (ref_tick) div_d = at_lim ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R4: a divided tick is never followed by another on the next cycle
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && lim != '0 && $stable(tick_sel)) |=> (!cnt_tick || lim == '0));
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             run,
  input  logic             periodic,
  input  logic [CNT_W-1:0] cmp,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt,
  output logic             match_evt,
  output logic             ovf_evt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] pend_val_q, pend_val_d;
  logic             pend_q, pend_d;
  logic             age_q, age_d;
  logic             load_w;
  logic             step_w;
  logic             hit_w;

  assign load_w    = cnt_tick && pend_q && age_q;
  assign step_w    = cnt_tick && run && !load_w;
  assign hit_w     = (cnt_q == cmp);
  assign match_evt = step_w && hit_w;
  assign ovf_evt   = step_w && (&cnt_q) && !hit_w;
  assign cnt       = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load_w)      cnt_d = pend_val_q;
    else if (step_w) cnt_d = (hit_w && periodic) ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    pend_d     = pend_q;
    pend_val_d = pend_val_q;
    age_d      = age_q;
    if (wr_cnt) begin
      pend_d     = 1'b1;
      pend_val_d = wr_val;
      age_d      = 1'b0;
    end else if (cnt_tick && pend_q) begin
      if (age_q) pend_d = 1'b0;
      age_d = ~age_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
      age_q      <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      pend_q     <= pend_d;
      pend_val_q <= pend_val_d;
      age_q      <= age_d;
    end
  end

  // R3: the count moves only on a count tick
  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick |=> $stable(cnt_q));
  // R5: a periodic match leaves the count at zero
  p_periodic_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && periodic) |=> (cnt_q == '0));
  // R12: a count write never lands on the cycle right after it
  p_no_early_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> !load_w);
endmodule

// File: rtl/cmt_regs.sv
module cmt_regs
  import cmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              match_evt,
  input  logic              ovf_evt,
  output logic [REG_W-1:0]  rdata,
  output ctl_t              ctl,
  output logic [CNT_W-1:0]  cmp,
  output logic              wr_cnt,
  output logic [CNT_W-1:0]  wr_val,
  output logic              irq,
  output logic              dma_req
);
  ctl_t             ctl_q, ctl_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             match_q, match_d;
  logic             ovf_q, ovf_d;
  logic             dma_q, dma_d;
  logic             wr_csr, wr_cmp;
  logic [REG_W-1:0] csr_view;

  assign wr_csr = wr_en && (addr == OFF_CSR);
  assign wr_cmp = wr_en && (addr == OFF_CMP);
  assign wr_cnt = wr_en && (addr == OFF_CNT);
  assign wr_val = wdata[CNT_W-1:0];

  always_comb begin
    ctl_d = ctl_q;
    if (wr_csr) begin
      ctl_d.periodic = wdata[BIT_PERIODIC];
      ctl_d.irq_en   = wdata[BIT_IRQ_EN];
      ctl_d.route    = route_e'(wdata[5:4]);
      ctl_d.tick_sel = wdata[2:0];
    end
    cmp_d   = wr_cmp ? wdata[CNT_W-1:0] : cmp_q;
    match_d = match_evt ? 1'b1 : ((wr_csr && !wdata[BIT_MATCH]) ? 1'b0 : match_q);
    ovf_d   = ovf_evt   ? 1'b1 : ((wr_csr && !wdata[BIT_OVF])   ? 1'b0 : ovf_q);
    dma_d   = match_evt && (ctl_q.route == ROUTE_DMA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      cmp_q   <= '1;
      match_q <= 1'b0;
      ovf_q   <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      cmp_q   <= cmp_d;
      match_q <= match_d;
      ovf_q   <= ovf_d;
      dma_q   <= dma_d;
    end
  end

  assign csr_view = {16'b0, match_q, ovf_q, 5'b0, ctl_q.periodic, ctl_q.irq_en,
                     1'b0, ctl_q.route, 1'b0, ctl_q.tick_sel};

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFF_CSR: rdata = csr_view;
        OFF_CNT: rdata = REG_W'(cnt);
        OFF_CMP: rdata = REG_W'(cmp_q);
        default: rdata = '0;
      endcase
    end
  end

  assign ctl     = ctl_q;
  assign cmp     = cmp_q;
  assign irq     = match_q && ctl_q.irq_en && (ctl_q.route == ROUTE_IRQ);
  assign dma_req = dma_q;

  // R7: the match flag rises only after a match event
  p_match_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_q) |-> $past(match_evt));
  // R9: the overflow flag rises only after a wrap event
  p_ovf_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(ovf_evt));
  // R11: a DMA pulse always follows a match under DMA routing
  p_dma_from_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> ($past(match_evt) && $past(ctl_q.route) == ROUTE_DMA));
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int START_W  = 8,
  parameter int CHAN_IDX = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic [START_W-1:0] start_bits,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [3:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               irq,
  output logic               dma_req
);
  ctl_t             ctl;
  logic [CNT_W-1:0] cmp, cnt, wr_val;
  logic             cnt_tick, wr_cnt, match_evt, ovf_evt, run;

  assign run = start_bits[CHAN_IDX];

  cmt_prescaler u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .tick_sel (ctl.tick_sel),
    .cnt_tick (cnt_tick)
  );

  cmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_tick  (cnt_tick),
    .run       (run),
    .periodic  (ctl.periodic),
    .cmp       (cmp),
    .wr_cnt    (wr_cnt),
    .wr_val    (wr_val),
    .cnt       (cnt),
    .match_evt (match_evt),
    .ovf_evt   (ovf_evt)
  );

  cmt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .cnt       (cnt),
    .match_evt (match_evt),
    .ovf_evt   (ovf_evt),
    .rdata     (rdata),
    .ctl       (ctl),
    .cmp       (cmp),
    .wr_cnt    (wr_cnt),
    .wr_val    (wr_val),
    .irq       (irq),
    .dma_req   (dma_req)
  );
endmodule

// File: tb/cmt_channel_test.sv
module cmt_channel_test;
  localparam int CW = 8;
  localparam int SW = 4;
  localparam int CI = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_tick = 1'b0;
  logic [SW-1:0] start_bits = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, dma_req;

  int checks = 0;
  int failures = 0;
  int dma_pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmt_channel #(.CNT_W(CW), .START_W(SW), .CHAN_IDX(CI)) uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .start_bits(start_bits),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .dma_req(dma_req)
  );

  always @(negedge clk) if (dma_req) dma_pulses++;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  // stop, load a count value through the two-tick delay, leave stopped
  task automatic preset(input logic [7:0] v, input int div);
    start_bits = '0;
    wr(4'h4, 32'(v));
    ticks(2 * div);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    int divs [4] = '{8, 32, 128, 1};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'h0, v); check("R1 csr", v, 0);
    rd(4'h4, v); check("R1 count", v, 0);
    rd(4'h8, v); check("R1 compare", v, 32'hFF);
    check("R1 irq", irq, 0);
    check("R1 dma", dma_req, 0);

    // R2 readback of fields, flags not set by writing ones, junk bits read 0
    wr(4'h0, 32'h0000_01B7); rd(4'h0, v); check("R2 csr fields", v, 32'h1B7);
    wr(4'h0, 32'hFFFF_C04F); rd(4'h0, v); check("R2 r8 junk and ones", v, 32'h7);

    // R3 other start bits ignored
    start_bits = 4'b1011;
    ticks(5); rd(4'h4, v); check("R3 other start bits", v, 0);
    start_bits = 4'b0100;
    // R4 selects 0..3 give no tick
    for (int s = 0; s < 4; s++) begin
      wr(4'h0, 32'(s)); ticks(4); rd(4'h4, v); check("R4 no-tick select", v, 0);
    end
    // R4 divider sweep
    for (int s = 4; s < 8; s++) begin
      wr(4'h0, 32'(s));
      preset(8'h00, divs[s-4]);
      start_bits = 4'b0100;
      ticks(3 * divs[s-4] - 1); rd(4'h4, v); check("R4 divider before edge", v, 2);
      ticks(1); rd(4'h4, v); check("R4 divider at edge", v, 3);
    end

    // R5 periodic, compare 9: period 10
    wr(4'h0, 32'h107); wr(4'h8, 32'd9); preset(8'h00, 1);
    wr(4'h0, 32'h107);
    start_bits = 4'b0100;
    for (int n = 1; n <= 25; n++) begin
      ticks(1); rd(4'h4, v); check("R5 periodic count", v, n % 10);
      if (n == 9)  begin rd(4'h0, v); check("R7 flag before match", v[15], 0); end
      if (n == 10) begin rd(4'h0, v); check("R7 flag after match", v[15], 1); end
    end
    // R8 write one keeps, write zero clears
    wr(4'h0, 32'h8107); rd(4'h0, v); check("R8 keep on one", v[15], 1);
    wr(4'h0, 32'h0107); rd(4'h0, v); check("R8 clear on zero", v[15], 0);

    // R6 / R9 free-running through match, overflow on wrap
    wr(4'h0, 32'h007); wr(4'h8, 32'h10); preset(8'h00, 1);
    wr(4'h0, 32'h007);
    start_bits = 4'b0100;
    ticks(17); rd(4'h4, v); check("R6 count past match", v, 17);
    rd(4'h0, v); check("R7 match flag free-run", v[15], 1); check("R9 no ovf yet", v[14], 0);
    ticks(238); rd(4'h4, v); check("R6 count at top", v, 255);
    rd(4'h0, v); check("R9 no ovf at top", v[14], 0);
    ticks(1); rd(4'h4, v); check("R6 wrap to zero", v, 0);
    rd(4'h0, v); check("R9 ovf on wrap", v[14], 1);
    wr(4'h0, 32'h4007); rd(4'h0, v); check("R8 ovf keep, match clear", v[15:14], 2'b01);
    wr(4'h0, 32'h0007); rd(4'h0, v); check("R8 ovf clear", v[14], 0);
    // R9 wrap caused by match at all ones: no overflow
    wr(4'h8, 32'hFF);
    ticks(256); rd(4'h4, v); check("R9 count after match wrap", v, 0);
    rd(4'h0, v); check("R9 match at top", v[15:14], 2'b10);

    // R13 lowering compare below the count
    wr(4'h0, 32'h107);
    ticks(20); wr(4'h8, 32'd5);
    ticks(10); rd(4'h4, v); check("R13 count keeps rising", v, 30);
    rd(4'h0, v); check("R13 no match above compare", v[15], 0);
    ticks(226); rd(4'h0, v); check("R13 wrap sets ovf", v[15:14], 2'b01);
    ticks(5); rd(4'h4, v); check("R13 reaches compare", v, 5);
    ticks(1); rd(4'h4, v); check("R13 periodic clear", v, 0);
    rd(4'h0, v); check("R13 match after wrap", v[15], 1);

    // R12 delayed count write
    wr(4'h0, 32'h107); wr(4'h8, 32'hFF);
    ticks(3); wr(4'h4, 32'h50);
    rd(4'h4, v); check("R12 not visible at once", v, 3);
    ticks(1); rd(4'h4, v); check("R12 first tick counts", v, 4);
    ticks(1); rd(4'h4, v); check("R12 second tick loads", v, 32'h50);
    ticks(1); rd(4'h4, v); check("R12 counts from loaded", v, 32'h51);

    // R10 interrupt routing
    dma_pulses = 0;
    wr(4'h0, 32'h1A7); wr(4'h8, 32'd3); wr(4'h4, 32'd0); ticks(2);
    check("R10 irq low before match", irq, 0);
    ticks(3); check("R10 irq low at count 3", irq, 0);
    ticks(1); @(negedge clk); check("R10 irq on match", irq, 1);
    wr(4'h0, 32'h8127); check("R10 irq off without enable", irq, 0);
    wr(4'h0, 32'h8187); check("R10 irq off with route none", irq, 0);
    wr(4'h0, 32'h81A7); check("R10 irq back on", irq, 1);
    wr(4'h0, 32'h01A7); check("R10 irq drops on clear", irq, 0);
    check("R11 no dma under irq route", dma_pulses, 0);

    // R11 DMA pulses, count now 0, period 4
    wr(4'h0, 32'h117); dma_pulses = 0;
    ticks(20); @(negedge clk);
    check("R11 dma pulse count", dma_pulses, 5);
    check("R10 irq low under dma route", irq, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule